// File: doc/BRIEF.md
# Segment Selector File with Hidden Descriptor Cache

This block keeps the six segment selectors of an address-generation stage together with a hidden cache entry for each one. An entry holds a 32-bit segment base, a 32-bit segment limit and an attribute byte. Software-visible selector loads arrive on the load port. In real mode the entry's base becomes the selector shifted left by four bits and the limit is forced to the fixed 64 KB size. In protected mode the base, limit and attributes come from descriptor fields that an upstream stage has already fetched.

A memory reference names a segment, an offset and an access length. The block adds the cached base to the offset to form the linear address. It also checks the last byte of the access against the cached limit. Results are registered, so they appear one cycle after the reference is presented. Every reference reads the cache contents as they stood before any load taking effect at the same clock edge.

The segment index order is fixed: 0 = CS, 1 = SS, 2 = DS, 3 = ES, 4 = FS, 5 = GS.

Top module: `seg_unit`

## Requirements
- R1: After reset every selector and every base is 0, every limit is 0x0000FFFF and every attribute byte is 0. The registered outputs `res_valid`, `res_fault`, `res_lin`, `res_sel` and `res_attr` are all 0.
- R2: A load with `prot_mode` = 0 to a valid index stores the selector. It sets that entry's base to the selector shifted left by 4 (upper bits zero) and its limit to 0x0000FFFF, and leaves its attribute byte unchanged.
- R3: A load with `prot_mode` = 1 to a valid index stores the selector, and takes base, limit and attributes from `ld_base`, `ld_limit` and `ld_attr`.
- R4: A reference accepted at a clock edge (`ref_valid` = 1) yields, right after that edge, `res_valid` = 1, `res_lin` = cached base + `ref_ofs` modulo 2^32, and the entry's selector and attributes on `res_sel` and `res_attr`.
- R5: `res_fault` is 1 for a valid-index reference exactly when `ref_ofs` + `ref_len` exceeds the cached limit. Here `ref_len` is the byte count minus one, and the sum is formed without wrap-around in 33 bits. A last byte equal to the limit is not a fault.
- R6: When a load and a reference name the same segment at the same edge, the reference result uses the entry as it was before that load.
- R7: An index of 6 or 7 is invalid. A load to it changes no entry. A reference to it gives `res_fault` = 1 with `res_lin`, `res_sel` and `res_attr` equal to 0.
- R8: In a cycle after an edge with `ref_valid` = 0, `res_valid` and `res_fault` are 0.
- R9: A load to one index leaves the selector, base, limit and attributes of every other index unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| prot_mode | input | 1 | 0 = real mode fill, 1 = protected mode fill |
| ld_valid | input | 1 | Selector load strobe |
| ld_seg | input | 3 | Segment index of the load |
| ld_sel | input | 16 | Selector value |
| ld_base | input | 32 | Descriptor base (protected mode) |
| ld_limit | input | 32 | Descriptor limit in bytes (protected mode) |
| ld_attr | input | 8 | Descriptor attribute byte (protected mode) |
| ref_valid | input | 1 | Memory reference strobe |
| ref_seg | input | 3 | Segment index of the reference |
| ref_ofs | input | 32 | Offset within the segment |
| ref_len | input | 4 | Access length in bytes minus one |
| res_valid | output | 1 | Registered result is for a reference |
| res_lin | output | 32 | Linear address |
| res_fault | output | 1 | Limit violation or invalid index |
| res_sel | output | 16 | Selector of the referenced segment |
| res_attr | output | 8 | Cached attributes of the referenced segment |

## Verification
The bench builds the block with its default parameters: six segments behind a 3-bit index, 32-bit base, limit and offset, and a 4-bit length field. The 3-bit index lets indices 6 and 7 reach the invalid-index path. The 16-byte maximum access length lets random offsets land exactly on, and just past, the limit boundary. The 32-bit offset also allows the last-byte sum to carry out of bit 31, which exercises the unwrapped comparison in R5.

// File: rtl/seg_pkg.sv
package seg_pkg;

    typedef enum logic [2:0] {
        SEG_CS = 3'd0,
        SEG_SS = 3'd1,
        SEG_DS = 3'd2,
        SEG_ES = 3'd3,
        SEG_FS = 3'd4,
        SEG_GS = 3'd5
    } seg_id_e;

    localparam int unsigned SEG_COUNT   = 6;
    localparam int unsigned REAL_SHIFT  = 4;
    localparam logic [31:0] REAL_LIMIT  = 32'h0000_FFFF;

endpackage

// File: rtl/seg_entry.sv
module seg_entry #(
    parameter int unsigned SEL_W      = 16,
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned ATTR_W     = 8,
    parameter int unsigned SHIFT      = 4,
    parameter logic [ADDR_W-1:0] FIXED_LIMIT = ADDR_W'(32'h0000_FFFF),
    parameter logic [ATTR_W-1:0] RST_ATTR    = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              prot_mode,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [ADDR_W-1:0] wr_base,
    input  logic [ADDR_W-1:0] wr_limit,
    input  logic [ATTR_W-1:0] wr_attr,
    output logic [SEL_W-1:0]  sel_q,
    output logic [ADDR_W-1:0] base_q,
    output logic [ADDR_W-1:0] limit_q,
    output logic [ATTR_W-1:0] attr_q
);

    logic [ADDR_W-1:0] real_base;
    logic              armed;

    always_comb begin
        real_base = ADDR_W'(wr_sel) << SHIFT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q   <= '0;
            base_q  <= '0;
            limit_q <= FIXED_LIMIT;
            attr_q  <= RST_ATTR;
        end else if (wr_en) begin
            sel_q <= wr_sel;
            if (prot_mode) begin
                base_q  <= wr_base;
                limit_q <= wr_limit;
                attr_q  <= wr_attr;
            end else begin
                base_q  <= real_base;
                limit_q <= FIXED_LIMIT;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R2: real-mode fill shifts the selector into the base and fixes the limit
    a_r2_real_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && wr_en && !prot_mode) |=>
            (base_q == (ADDR_W'($past(wr_sel)) << SHIFT)) && (limit_q == FIXED_LIMIT)
            && (sel_q == $past(wr_sel)));

    // R2: real-mode fill keeps the attribute byte
    a_r2_attr_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && wr_en && !prot_mode) |=> $stable(attr_q));

    // R3: protected-mode fill copies descriptor fields
    a_r3_prot_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && wr_en && prot_mode) |=>
            (base_q == $past(wr_base)) && (limit_q == $past(wr_limit))
            && (attr_q == $past(wr_attr)));

    // R9: no write leaves the entry untouched
    a_r9_entry_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !wr_en) |=>
            $stable(sel_q) && $stable(base_q) && $stable(limit_q) && $stable(attr_q));

endmodule

// File: rtl/seg_ref_path.sv
module seg_ref_path #(
    parameter int unsigned SEL_W  = 16,
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned ATTR_W = 8,
    parameter int unsigned LEN_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_valid,
    input  logic              idx_ok,
    input  logic [ADDR_W-1:0] ref_ofs,
    input  logic [LEN_W-1:0]  ref_len,
    input  logic [ADDR_W-1:0] ent_base,
    input  logic [ADDR_W-1:0] ent_limit,
    input  logic [SEL_W-1:0]  ent_sel,
    input  logic [ATTR_W-1:0] ent_attr,
    output logic              res_valid,
    output logic [ADDR_W-1:0] res_lin,
    output logic              res_fault,
    output logic [SEL_W-1:0]  res_sel,
    output logic [ATTR_W-1:0] res_attr
);

    localparam int unsigned SUM_W = ADDR_W + 1;

    logic [SUM_W-1:0]  last_byte;
    logic              over_limit;
    logic [ADDR_W-1:0] lin_next;
    logic              armed;

    always_comb begin
        last_byte  = {1'b0, ref_ofs} + SUM_W'(ref_len);
        over_limit = last_byte > {1'b0, ent_limit};
        lin_next   = ent_base + ref_ofs;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_lin   <= '0;
            res_fault <= 1'b0;
            res_sel   <= '0;
            res_attr  <= '0;
        end else if (ref_valid) begin
            res_valid <= 1'b1;
            if (idx_ok) begin
                res_lin   <= lin_next;
                res_fault <= over_limit;
                res_sel   <= ent_sel;
                res_attr  <= ent_attr;
            end else begin
                res_lin   <= '0;
                res_fault <= 1'b1;
                res_sel   <= '0;
                res_attr  <= '0;
            end
        end else begin
            res_valid <= 1'b0;
            res_fault <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R4: a result follows each accepted reference by one cycle
    a_r4_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (res_valid == $past(ref_valid)));

    // R7: an invalid index always reports a fault
    a_r7_bad_index: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && ref_valid && !idx_ok) |=> (res_fault && res_lin == '0));

    // R8: no fault without a result
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> !res_fault);

endmodule

// File: rtl/seg_unit.sv
module seg_unit
    import seg_pkg::*;
#(
    parameter int unsigned NUM_SEG = SEG_COUNT,
    parameter int unsigned SEL_W   = 16,
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned ATTR_W  = 8,
    parameter int unsigned LEN_W   = 4,
    parameter int unsigned IDX_W   = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prot_mode,
    input  logic              ld_valid,
    input  logic [IDX_W-1:0]  ld_seg,
    input  logic [SEL_W-1:0]  ld_sel,
    input  logic [ADDR_W-1:0] ld_base,
    input  logic [ADDR_W-1:0] ld_limit,
    input  logic [ATTR_W-1:0] ld_attr,
    input  logic              ref_valid,
    input  logic [IDX_W-1:0]  ref_seg,
    input  logic [ADDR_W-1:0] ref_ofs,
    input  logic [LEN_W-1:0]  ref_len,
    output logic              res_valid,
    output logic [ADDR_W-1:0] res_lin,
    output logic              res_fault,
    output logic [SEL_W-1:0]  res_sel,
    output logic [ATTR_W-1:0] res_attr
);

    localparam logic [ADDR_W-1:0] LIM_RST = ADDR_W'(REAL_LIMIT);

    logic [SEL_W-1:0]  sel_a   [NUM_SEG];
    logic [ADDR_W-1:0] base_a  [NUM_SEG];
    logic [ADDR_W-1:0] limit_a [NUM_SEG];
    logic [ATTR_W-1:0] attr_a  [NUM_SEG];
    logic [NUM_SEG-1:0] wr_vec;

    logic              idx_ok;
    logic [SEL_W-1:0]  pick_sel;
    logic [ADDR_W-1:0] pick_base;
    logic [ADDR_W-1:0] pick_limit;
    logic [ATTR_W-1:0] pick_attr;

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_ent
        assign wr_vec[g] = ld_valid && (ld_seg == IDX_W'(g));

        seg_entry #(
            .SEL_W      (SEL_W),
            .ADDR_W     (ADDR_W),
            .ATTR_W     (ATTR_W),
            .SHIFT      (REAL_SHIFT),
            .FIXED_LIMIT(LIM_RST),
            .RST_ATTR   ('0)
        ) u_ent (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_vec[g]),
            .prot_mode(prot_mode),
            .wr_sel   (ld_sel),
            .wr_base  (ld_base),
            .wr_limit (ld_limit),
            .wr_attr  (ld_attr),
            .sel_q    (sel_a[g]),
            .base_q   (base_a[g]),
            .limit_q  (limit_a[g]),
            .attr_q   (attr_a[g])
        );
    end

    always_comb begin
        idx_ok     = {1'b0, ref_seg} < (IDX_W+1)'(NUM_SEG);
        pick_sel   = '0;
        pick_base  = '0;
        pick_limit = '0;
        pick_attr  = '0;
        for (int i = 0; i < NUM_SEG; i++) begin
            if (ref_seg == IDX_W'(i)) begin
                pick_sel   = sel_a[i];
                pick_base  = base_a[i];
                pick_limit = limit_a[i];
                pick_attr  = attr_a[i];
            end
        end
    end

    seg_ref_path #(
        .SEL_W (SEL_W),
        .ADDR_W(ADDR_W),
        .ATTR_W(ATTR_W),
        .LEN_W (LEN_W)
    ) u_ref (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_valid(ref_valid),
        .idx_ok   (idx_ok),
        .ref_ofs  (ref_ofs),
        .ref_len  (ref_len),
        .ent_base (pick_base),
        .ent_limit(pick_limit),
        .ent_sel  (pick_sel),
        .ent_attr (pick_attr),
        .res_valid(res_valid),
        .res_lin  (res_lin),
        .res_fault(res_fault),
        .res_sel  (res_sel),
        .res_attr (res_attr)
    );

    // R7 / R9: at most one entry is written per cycle, none for an invalid index
    a_r7_one_write: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_vec) && ((wr_vec == '0) || ld_valid));

endmodule

// File: tb/seg_unit_bench.sv
module seg_unit_bench;

    localparam int CLK_P = 10;
    localparam int NSEG  = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prot_mode = 1'b0;
    logic        ld_valid = 1'b0;
    logic [2:0]  ld_seg = '0;
    logic [15:0] ld_sel = '0;
    logic [31:0] ld_base = '0;
    logic [31:0] ld_limit = '0;
    logic [7:0]  ld_attr = '0;
    logic        ref_valid = 1'b0;
    logic [2:0]  ref_seg = '0;
    logic [31:0] ref_ofs = '0;
    logic [3:0]  ref_len = '0;
    logic        res_valid;
    logic [31:0] res_lin;
    logic        res_fault;
    logic [15:0] res_sel;
    logic [7:0]  res_attr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [15:0] m_sel   [NSEG];
    logic [31:0] m_base  [NSEG];
    logic [31:0] m_limit [NSEG];
    logic [7:0]  m_attr  [NSEG];

    always #(CLK_P/2) clk = ~clk;

    seg_unit u_seg_unit (
        .clk(clk), .rst_n(rst_n), .prot_mode(prot_mode),
        .ld_valid(ld_valid), .ld_seg(ld_seg), .ld_sel(ld_sel),
        .ld_base(ld_base), .ld_limit(ld_limit), .ld_attr(ld_attr),
        .ref_valid(ref_valid), .ref_seg(ref_seg), .ref_ofs(ref_ofs), .ref_len(ref_len),
        .res_valid(res_valid), .res_lin(res_lin), .res_fault(res_fault),
        .res_sel(res_sel), .res_attr(res_attr)
    );

    function automatic logic exp_fault(input logic [31:0] ofs, input logic [3:0] len,
                                       input logic [31:0] lim);
        return ({1'b0, ofs} + 33'(len)) > {1'b0, lim};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic pm, input logic lv, input logic [2:0] ls,
                        input logic [15:0] sel, input logic [31:0] base,
                        input logic [31:0] lim, input logic [7:0] attr,
                        input logic rv, input logic [2:0] rs,
                        input logic [31:0] ofs, input logic [3:0] len, input string tag);
        logic [31:0] e_lin;
        logic        e_flt;
        logic [15:0] e_sel;
        logic [7:0]  e_attr;
        @(negedge clk);
        prot_mode = pm; ld_valid = lv; ld_seg = ls; ld_sel = sel;
        ld_base = base; ld_limit = lim; ld_attr = attr;
        ref_valid = rv; ref_seg = rs; ref_ofs = ofs; ref_len = len;
        if (rs < NSEG) begin
            e_lin  = m_base[rs] + ofs;
            e_flt  = exp_fault(ofs, len, m_limit[rs]);
            e_sel  = m_sel[rs];
            e_attr = m_attr[rs];
        end else begin
            e_lin = '0; e_flt = 1'b1; e_sel = '0; e_attr = '0;
        end
        @(posedge clk);
        #1;
        chk({tag, " R4 valid"}, 32'(res_valid), 32'(rv));
        if (rv) begin
            chk({tag, " R4 lin"}, res_lin, e_lin);
            chk({tag, " R5 fault"}, 32'(res_fault), 32'(e_flt));
            chk({tag, " R4 sel"}, 32'(res_sel), 32'(e_sel));
            chk({tag, " R4 attr"}, 32'(res_attr), 32'(e_attr));
        end else begin
            chk({tag, " R8 fault idle"}, 32'(res_fault), 32'h0);
        end
        if (lv && ls < NSEG) begin
            m_sel[ls] = sel;
            if (pm) begin
                m_base[ls] = base; m_limit[ls] = lim; m_attr[ls] = attr;
            end else begin
                m_base[ls] = {12'h0, sel, 4'h0}; m_limit[ls] = 32'h0000_FFFF;
            end
        end
    endtask

    task automatic probe_all(input string tag);
        for (int s = 0; s < NSEG; s++)
            step(1'b0, 1'b0, 3'd0, 16'h0, 32'h0, 32'h0, 8'h0, 1'b1, 3'(s), 32'h10, 4'd0, tag);
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1BAD_5EED));
        for (int s = 0; s < NSEG; s++) begin
            m_sel[s] = '0; m_base[s] = '0; m_limit[s] = 32'h0000_FFFF; m_attr[s] = '0;
        end
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset valid", 32'(res_valid), 32'h0);
        chk("R1 reset lin", res_lin, 32'h0);
        chk("R1 reset fault", 32'(res_fault), 32'h0);
        chk("R1 reset sel", 32'(res_sel), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        probe_all("R1 entries");

        // R2: real-mode load of DS, attributes kept
        step(1'b0, 1'b1, 3'd2, 16'hB800, 32'hDEAD_0000, 32'h1, 8'h5A, 1'b0, 3'd0, 32'h0, 4'd0, "R2 load");
        step(1'b0, 1'b0, 3'd0, 16'h0, 32'h0, 32'h0, 8'h0, 1'b1, 3'd2, 32'h0000_0123, 4'd1, "R2 ref");
        step(1'b0, 1'b0, 3'd0, 16'h0, 32'h0, 32'h0, 8'h0, 1'b1, 3'd2, 32'h0000_FFFF, 4'd0, "R5 exact limit");
        step(1'b0, 1'b0, 3'd0, 16'h0, 32'h0, 32'h0, 8'h0, 1'b1, 3'd2, 32'h0000_FFFF, 4'd1, "R5 one over");

        // R3: protected load of GS, then R9 check of other entries
        step(1'b1, 1'b1, 3'd5, 16'h002B, 32'hFFFF_F000, 32'h0000_0FFF, 8'hF3, 1'b0, 3'd0, 32'h0, 4'd0, "R3 load");
        step(1'b0, 1'b0, 3'd0, 16'h0, 32'h0, 32'h0, 8'h0, 1'b1, 3'd5, 32'h0000_0FF8, 4'd7, "R3 ref edge");
        step(1'b0, 1'b0, 3'd0, 16'h0, 32'h0, 32'h0, 8'h0, 1'b1, 3'd5, 32'h0000_1000, 4'd0, "R4 wrap lin R5");
        probe_all("R9 others");

        // R5: carry out of bit 31 with a full limit
        step(1'b1, 1'b1, 3'd1, 16'h0010, 32'h0000_0100, 32'hFFFF_FFFF, 8'h93, 1'b0, 3'd0, 32'h0, 4'd0, "R3 load SS");
        step(1'b0, 1'b0, 3'd0, 16'h0, 32'h0, 32'h0, 8'h0, 1'b1, 3'd1, 32'hFFFF_FFFF, 4'd1, "R5 carry");
        step(1'b0, 1'b0, 3'd0, 16'h0, 32'h0, 32'h0, 8'h0, 1'b1, 3'd1, 32'hFFFF_FFFF, 4'd0, "R5 top byte");

        // R6: load and reference of CS at one edge
        step(1'b1, 1'b1, 3'd0, 16'h0008, 32'h1234_0000, 32'h0000_000F, 8'h9B, 1'b1, 3'd0, 32'h0000_0020, 4'd3, "R6 same edge");
        step(1'b0, 1'b0, 3'd0, 16'h0, 32'h0, 32'h0, 8'h0, 1'b1, 3'd0, 32'h0000_000C, 4'd3, "R6 after");

        // R7: invalid indices
        step(1'b1, 1'b1, 3'd6, 16'hFFFF, 32'hAAAA_AAAA, 32'h0, 8'hFF, 1'b1, 3'd7, 32'h0, 4'd0, "R7 bad");
        probe_all("R7 no change");

        // R8: idle
        step(1'b0, 1'b0, 3'd0, 16'h0, 32'h0, 32'h0, 8'h0, 1'b0, 3'd0, 32'h0, 4'd0, "R8 idle");

        // Random mix
        for (int n = 0; n < 600; n++) begin
            logic [2:0]  rs;
            logic [3:0]  len;
            logic [31:0] ofs;
            logic [31:0] lim;
            rs  = 3'($urandom_range(0, 7));
            len = 4'($urandom);
            lim = ($urandom_range(0, 1) == 1) ? $urandom : 32'($urandom_range(0, 4095));
            case ($urandom_range(0, 3))
                0: ofs = $urandom;
                1: ofs = (rs < NSEG) ? m_limit[rs] - 32'(len) : 32'h0;
                2: ofs = (rs < NSEG) ? m_limit[rs] - 32'(len) + 32'd1 : 32'h0;
                default: ofs = 32'($urandom_range(0, 255));
            endcase
            step(1'($urandom), 1'($urandom), 3'($urandom_range(0, 7)), 16'($urandom),
                 $urandom, lim, 8'($urandom), 1'($urandom_range(0, 3) != 0), rs, ofs, len,
                 "random R2 R3 R4 R5 R6 R7 R9");
        end

        done = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule